// File: doc/BRIEF.md
# Aperture Page Remapping Table

This block remaps a fixed, contiguous window of bus addresses (the aperture) onto scattered physical memory, one 4 KiB page at a time. It keeps an on-chip table with one entry per aperture page. Each entry carries a valid flag and a physical page frame. Each translation request gets back, one cycle later, either the physical address (the page frame joined with the untouched low 12 address bits) or a fault.

Software reaches the table only indirectly. It first writes a page-select register with an aperture byte address, then reads or writes a data register that stands for the selected entry. A single enable bit in a control register switches all translation on or off. Software can read the control register back to confirm that its earlier register writes have landed. A translation faults when translation is disabled, when the request lies outside the aperture, or when the selected entry is not valid.

Top module: `aperture_remap`

## Requirements
- R1: After reset the control register reads 0, every table entry reads 0, and every translation request faults.
- R2: Control register (offset 0x0): bit 0 is the translation enable. A read returns the stored bit in bit 0 and zeros in bits 31:1.
- R3: Page-select register (offset 0x4): a write keeps bits 31:12 of the written data, and a read returns those bits with bits 11:0 as zero.
- R4: Entry data register (offset 0x8): a write stores bit 31 (valid) and bits 30:12 (page frame) into the selected entry. A read returns them, with bits 11:0 as zero.
- R5: A request whose address lies in the aperture, while translation is enabled, that selects a valid entry returns the physical address {0, frame, request[11:0]} with the fault flag low. The entry index is (address − base) >> 12.
- R6: While the enable bit is 0, every translation request faults.
- R7: A request below the aperture base, or at or above base + 4096 × page count, faults.
- R8: A request that selects an entry with bit 31 clear faults, so writing zero to an entry unmaps its page.
- R9: When a response faults, its physical address output is zero.
- R10: While the page-select register points outside the aperture, an entry data write changes no entry and an entry data read returns zero.
- R11: When an entry data write and a translation request for the same page fall in the same cycle, that translation uses the old entry. The next request sees the new one.
- R12: A register read returns its data on the cycle after the read strobe. A translation response is valid exactly on the cycle after each request and is idle (all zero) otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| xl_req_valid | input | 1 | Translation request strobe |
| xl_req_addr | input | 32 | Translation request bus address |
| xl_resp_valid | output | 1 | Translation response valid |
| xl_resp_paddr | output | 32 | Translated physical address (zero on fault) |
| xl_resp_fault | output | 1 | Translation fault flag |

## Verification
An entry data write through the register port and a translation lookup of that same page can land in one clock edge. The bench provokes this by raising the data write strobe and the request strobe in the same cycle after selecting a mapped page. It expects the response to carry the old frame, and the next request to the same page to carry the new one. The same pairing is judged for the control bit: a request issued while the enable is being written is answered under the old enable value.

// File: rtl/aperture_remap_pkg.sv
// Package: shared constants, entry type and window helper for the
// aperture remapping table. Assumes 32-bit bus addresses and 4 KiB pages.
package aperture_remap_pkg;

    localparam int unsigned PAGE_SHIFT = 12;
    localparam int unsigned FRAME_W    = 31 - PAGE_SHIFT;
    localparam int unsigned REG_AW     = 4;

    localparam logic [REG_AW-1:0] OFF_CTRL  = 4'h0;
    localparam logic [REG_AW-1:0] OFF_PSEL  = 4'h4;
    localparam logic [REG_AW-1:0] OFF_EDATA = 4'h8;

    // One table entry: valid flag and physical page frame.
    typedef struct packed {
        logic               valid;
        logic [FRAME_W-1:0] frame;
    } pte_t;

    // True when address a lies in [base, lim) with lim held in 33 bits.
    function automatic logic in_window(input logic [31:0] a,
                                       input logic [31:0] base,
                                       input logic [32:0] lim);
        return ({1'b0, a} >= {1'b0, base}) && ({1'b0, a} < lim);
    endfunction

endpackage

// File: rtl/aperture_remap_table.sv
// Module: entry storage. One register per page, cleared to invalid on
// reset, with one write port and two independent combinational read
// ports (register side and translation side). A write updates at the
// clock edge, so a same-cycle read still sees the previous entry.
// Assumes every index presented is below NUM_PAGES.
module aperture_remap_table
    import aperture_remap_pkg::*;
#(
    parameter int unsigned NUM_PAGES = 32,
    localparam int unsigned IDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  pte_t             wr_entry,
    input  logic [IDX_W-1:0] rd_idx_a,
    output pte_t             rd_entry_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output pte_t             rd_entry_b
);

    pte_t slots [NUM_PAGES];

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_slot
        // Hold one page entry; clear on reset, load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slots[g] <= wr_entry;
            end
        end
    end

    // Register-side read port.
    always_comb rd_entry_a = slots[rd_idx_a];

    // Translation-side read port.
    always_comb rd_entry_b = slots[rd_idx_b];

endmodule

// File: rtl/aperture_remap_regs.sv
// Module: register window. Holds the enable bit and the page-select
// register, turns entry data accesses into table writes and reads, and
// registers the read data one cycle after the read strobe. Entry data
// accesses with the page select outside the aperture write nothing and
// read zero. Unknown offsets read zero and ignore writes.
module aperture_remap_regs
    import aperture_remap_pkg::*;
#(
    parameter logic [31:0] APER_BASE = 32'h4000_0000,
    parameter int unsigned NUM_PAGES = 32,
    localparam int unsigned IDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam logic [32:0] APER_LIM =
        {1'b0, APER_BASE} + ({1'b0, 32'(NUM_PAGES)} << PAGE_SHIFT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              cfg_en,
    output logic              tbl_wr_en,
    output logic [IDX_W-1:0]  tbl_idx,
    output pte_t              tbl_wr_entry,
    input  pte_t              tbl_rd_entry
);

    logic [31-PAGE_SHIFT:0] psel_q;
    logic [31:0]            psel_addr;
    logic [31:0]            psel_off;
    logic                   psel_in;
    logic [31:0]            rd_mux;
    logic                   unused_bits;

    // Enable bit: cleared on reset, loaded from bit 0 on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en <= 1'b0;
        end else if (reg_wr && (reg_addr == OFF_CTRL)) begin
            cfg_en <= reg_wdata[0];
        end
    end

    // Page-select register: keeps only the page-number bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psel_q <= '0;
        end else if (reg_wr && (reg_addr == OFF_PSEL)) begin
            psel_q <= reg_wdata[31:PAGE_SHIFT];
        end
    end

    // Turn the selected aperture address into a table index and range flag.
    always_comb begin
        psel_addr = {psel_q, {PAGE_SHIFT{1'b0}}};
        psel_off  = psel_addr - APER_BASE;
        psel_in   = in_window(psel_addr, APER_BASE, APER_LIM);
        tbl_idx   = psel_off[PAGE_SHIFT +: IDX_W];
    end

    // Entry data writes reach the table only while the select is in range.
    always_comb begin
        tbl_wr_en          = reg_wr && (reg_addr == OFF_EDATA) && psel_in;
        tbl_wr_entry.valid = reg_wdata[31];
        tbl_wr_entry.frame = reg_wdata[30:PAGE_SHIFT];
    end

    // Select the read value for the addressed register.
    always_comb begin
        unique case (reg_addr)
            OFF_CTRL:  rd_mux = {31'b0, cfg_en};
            OFF_PSEL:  rd_mux = psel_addr;
            OFF_EDATA: rd_mux = psel_in ? {tbl_rd_entry.valid, tbl_rd_entry.frame,
                                           {PAGE_SHIFT{1'b0}}} : 32'b0;
            default:   rd_mux = 32'b0;
        endcase
    end

    // Read data register: updated on each read strobe, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

    assign unused_bits = ^{reg_wdata[PAGE_SHIFT-1:1], psel_off};

endmodule

// File: rtl/aperture_remap_xlate.sv
// Module: translation path. Checks the request against the aperture,
// looks up the entry and registers a one-cycle response. A fault wins
// over the address, which is then forced to zero. The response register
// samples the table before any same-edge write takes effect.
module aperture_remap_xlate
    import aperture_remap_pkg::*;
#(
    parameter logic [31:0] APER_BASE = 32'h4000_0000,
    parameter int unsigned NUM_PAGES = 32,
    localparam int unsigned IDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam logic [32:0] APER_LIM =
        {1'b0, APER_BASE} + ({1'b0, 32'(NUM_PAGES)} << PAGE_SHIFT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [31:0]      req_addr,
    input  logic             cfg_en,
    output logic [IDX_W-1:0] lookup_idx,
    input  pte_t             lookup_entry,
    output logic             resp_valid,
    output logic [31:0]      resp_paddr,
    output logic             resp_fault
);

    logic [31:0] req_off;
    logic        req_in;
    logic        hit_fault;
    logic [31:0] hit_paddr;
    logic        unused_bits;

    // Index and window check for the incoming address.
    always_comb begin
        req_off    = req_addr - APER_BASE;
        req_in     = in_window(req_addr, APER_BASE, APER_LIM);
        lookup_idx = req_off[PAGE_SHIFT +: IDX_W];
    end

    // Fault decision and address assembly; the fault takes priority.
    always_comb begin
        hit_fault = !cfg_en || !req_in || !lookup_entry.valid;
        hit_paddr = hit_fault ? 32'b0
                              : {1'b0, lookup_entry.frame, req_addr[PAGE_SHIFT-1:0]};
    end

    // Response register: one cycle after a request, all zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_paddr <= '0;
            resp_fault <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            resp_paddr <= req_valid ? hit_paddr : 32'b0;
            resp_fault <= req_valid && hit_fault;
        end
    end

    assign unused_bits = ^req_off;

endmodule

// File: rtl/aperture_remap.sv
// Module: top of the aperture remapping table. Connects the register
// window, entry storage and translation path. Assumes APER_BASE is 4 KiB
// aligned and the aperture does not wrap past the top of the bus space.
module aperture_remap
    import aperture_remap_pkg::*;
#(
    parameter logic [31:0] APER_BASE = 32'h4000_0000,
    parameter int unsigned NUM_PAGES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        xl_req_valid,
    input  logic [31:0] xl_req_addr,
    output logic        xl_resp_valid,
    output logic [31:0] xl_resp_paddr,
    output logic        xl_resp_fault
);

    localparam int unsigned IDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

    logic             cfg_en;
    logic             tbl_wr_en;
    logic [IDX_W-1:0] tbl_idx;
    pte_t             tbl_wr_entry;
    pte_t             tbl_rd_entry;
    logic [IDX_W-1:0] xl_idx;
    pte_t             xl_entry;

    aperture_remap_regs #(
        .APER_BASE (APER_BASE),
        .NUM_PAGES (NUM_PAGES)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .cfg_en       (cfg_en),
        .tbl_wr_en    (tbl_wr_en),
        .tbl_idx      (tbl_idx),
        .tbl_wr_entry (tbl_wr_entry),
        .tbl_rd_entry (tbl_rd_entry)
    );

    aperture_remap_table #(
        .NUM_PAGES (NUM_PAGES)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tbl_wr_en),
        .wr_idx     (tbl_idx),
        .wr_entry   (tbl_wr_entry),
        .rd_idx_a   (tbl_idx),
        .rd_entry_a (tbl_rd_entry),
        .rd_idx_b   (xl_idx),
        .rd_entry_b (xl_entry)
    );

    aperture_remap_xlate #(
        .APER_BASE (APER_BASE),
        .NUM_PAGES (NUM_PAGES)
    ) u_xlate (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (xl_req_valid),
        .req_addr     (xl_req_addr),
        .cfg_en       (cfg_en),
        .lookup_idx   (xl_idx),
        .lookup_entry (xl_entry),
        .resp_valid   (xl_resp_valid),
        .resp_paddr   (xl_resp_paddr),
        .resp_fault   (xl_resp_fault)
    );

endmodule

// File: rtl/aperture_remap_checker.sv
// Module: property checker for the aperture remapping table, bound to
// every instance of the top. Armed one cycle after reset is released so
// no $past reaches back into reset.
module aperture_remap_checker
    import aperture_remap_pkg::*;
#(
    parameter logic [31:0] APER_BASE = 32'h4000_0000,
    parameter int unsigned NUM_PAGES = 32,
    localparam logic [32:0] APER_LIM =
        {1'b0, APER_BASE} + ({1'b0, 32'(NUM_PAGES)} << PAGE_SHIFT)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_en,
    input logic        xl_req_valid,
    input logic [31:0] xl_req_addr,
    input logic        xl_resp_valid,
    input logic [31:0] xl_resp_paddr,
    input logic        xl_resp_fault
);

    logic armed;

    // Arm the checks once a clock edge has passed out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_REQ_GETS_RESP: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        xl_req_valid |=> xl_resp_valid); // R12
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !xl_req_valid |=> !xl_resp_valid); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !xl_resp_valid |-> (!xl_resp_fault && xl_resp_paddr == 32'b0)); // R12
    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (xl_resp_valid && xl_resp_fault) |-> (xl_resp_paddr == 32'b0)); // R9
    AST_DISABLED_FAULTS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (xl_req_valid && !cfg_en) |=> xl_resp_fault); // R6
    AST_OUTSIDE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (xl_req_valid && !in_window(xl_req_addr, APER_BASE, APER_LIM)) |=> xl_resp_fault); // R7
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (xl_resp_valid && !xl_resp_fault) |->
            (xl_resp_paddr[PAGE_SHIFT-1:0] == $past(xl_req_addr[PAGE_SHIFT-1:0])
             && !xl_resp_paddr[31])); // R5

endmodule

bind aperture_remap aperture_remap_checker #(
    .APER_BASE (APER_BASE),
    .NUM_PAGES (NUM_PAGES)
) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_en        (cfg_en),
    .xl_req_valid  (xl_req_valid),
    .xl_req_addr   (xl_req_addr),
    .xl_resp_valid (xl_resp_valid),
    .xl_resp_paddr (xl_resp_paddr),
    .xl_resp_fault (xl_resp_fault)
);

// File: tb/aperture_remap_bench.sv
`timescale 1ns/1ps
// Bench: sweeps every page of a small 8-page aperture with computed
// frames and offsets, plus range edges, enable, unmap and same-cycle cases.
module aperture_remap_bench;

    localparam logic [31:0] BASE  = 32'h0010_0000;
    localparam int          PAGES = 8;
    localparam logic [31:0] LIM   = BASE + PAGES * 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xl_req_valid = 1'b0;
    logic [31:0] xl_req_addr = '0;
    logic        xl_resp_valid;
    logic [31:0] xl_resp_paddr;
    logic        xl_resp_fault;

    int checks = 0;
    int failures = 0;
    logic [31:0] model [PAGES];
    logic        en_model = 1'b0;

    always #2.5 clk = ~clk;

    aperture_remap #(.APER_BASE(BASE), .NUM_PAGES(PAGES)) u_aperture_remap (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xl_req_valid(xl_req_valid), .xl_req_addr(xl_req_addr),
        .xl_resp_valid(xl_resp_valid), .xl_resp_paddr(xl_resp_paddr),
        .xl_resp_fault(xl_resp_fault)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk); #1;
        d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Expected response from the requirements: fault flag and address.
    function automatic logic [32:0] expect_xl(input logic [31:0] a);
        logic        inwin;
        logic [31:0] e;
        inwin = (a >= BASE) && (a < LIM);
        e = inwin ? model[(a - BASE) >> 12] : 32'b0;
        if (!en_model || !inwin || !e[31]) return {1'b1, 32'b0};
        return {1'b0, 1'b0, e[30:12], a[11:0]};
    endfunction

    // Issue one request, check the response and the idle cycle after it.
    task automatic xl_check(input string req, input logic [31:0] a);
        logic [32:0] exp;
        exp = expect_xl(a);
        @(negedge clk);
        xl_req_valid = 1'b1; xl_req_addr = a;
        @(posedge clk); #1;
        chk("R12 resp valid", {31'b0, xl_resp_valid}, 32'd1);
        chk(req, {31'b0, xl_resp_fault}, {31'b0, exp[32]});
        chk({req, " R9 addr"}, xl_resp_paddr, exp[31:0]);
        @(negedge clk);
        xl_req_valid = 1'b0;
        @(posedge clk); #1;
        chk("R12 idle", {30'b0, xl_resp_valid, xl_resp_fault}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < PAGES; i++) model[i] = 32'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        rd_reg(4'h0, d); chk("R1 ctrl", d, 32'h0);
        for (int i = 0; i < PAGES; i++) begin
            wr_reg(4'h4, BASE + i * 4096);
            rd_reg(4'h8, d); chk("R1 entry", d, 32'h0);
        end
        xl_check("R1 fault after reset", BASE);

        // R3: page select keeps 31:12
        wr_reg(4'h4, 32'h0010_3ABC);
        rd_reg(4'h4, d); chk("R3 psel", d, 32'h0010_3000);

        // R4: fill every entry, low bits dropped
        for (int i = 0; i < PAGES; i++) begin
            model[i] = 32'h8000_0000 | ((32'h1234 + i * 37) << 12);
            wr_reg(4'h4, BASE + i * 4096 + 32'h10);
            wr_reg(4'h8, model[i] | 32'hFFF);
        end
        for (int i = 0; i < PAGES; i++) begin
            wr_reg(4'h4, BASE + i * 4096);
            rd_reg(4'h8, d); chk("R4 entry readback", d, model[i]);
        end

        // R6: still disabled, mapped pages fault
        for (int i = 0; i < PAGES; i++) xl_check("R6 disabled", BASE + i * 4096);

        // R2: enable and read back
        wr_reg(4'h0, 32'hFFFF_FFFF); en_model = 1'b1;
        rd_reg(4'h0, d); chk("R2 ctrl", d, 32'h1);

        // R5: every page with several offsets
        for (int i = 0; i < PAGES; i++) begin
            xl_check("R5 hit", BASE + i * 4096);
            xl_check("R5 hit", BASE + i * 4096 + 32'h5A5);
            xl_check("R5 hit", BASE + i * 4096 + 32'hFFF);
        end

        // R7: edges of the window
        xl_check("R7 below", BASE - 1);
        xl_check("R7 below", BASE - 4096);
        xl_check("R7 below", 32'h0);
        xl_check("R7 at end", LIM);
        xl_check("R7 above", LIM + 32'h10);
        xl_check("R7 top", 32'hFFFF_FFFF);

        // R6: disable again, then re-enable
        wr_reg(4'h0, 32'h0); en_model = 1'b0;
        rd_reg(4'h0, d); chk("R2 ctrl clear", d, 32'h0);
        for (int i = 0; i < PAGES; i++) xl_check("R6 disabled", BASE + i * 4096 + 32'h77);
        wr_reg(4'h0, 32'h1); en_model = 1'b1;

        // R8: unmap with zero, and valid clear with a frame
        wr_reg(4'h4, BASE + 3 * 4096);
        wr_reg(4'h8, 32'h0); model[3] = 32'h0;
        xl_check("R8 unmapped", BASE + 3 * 4096 + 32'h20);
        wr_reg(4'h4, BASE + 5 * 4096);
        wr_reg(4'h8, 32'h0005_5000); model[5] = 32'h0005_5000;
        xl_check("R8 invalid", BASE + 5 * 4096);

        // R10: select outside aperture
        wr_reg(4'h4, LIM);
        wr_reg(4'h8, 32'h8000_1000);
        rd_reg(4'h8, d); chk("R10 read outside", d, 32'h0);
        wr_reg(4'h4, BASE - 4096);
        wr_reg(4'h8, 32'h8000_2000);
        rd_reg(4'h8, d); chk("R10 read below", d, 32'h0);
        for (int i = 0; i < PAGES; i++) begin
            wr_reg(4'h4, BASE + i * 4096);
            rd_reg(4'h8, d); chk("R10 entries unchanged", d, model[i]);
        end

        // R11: same-cycle entry write and request to page 2
        wr_reg(4'h4, BASE + 2 * 4096);
        begin
            logic [32:0] old_exp;
            old_exp = expect_xl(BASE + 2 * 4096 + 32'h321);
            @(negedge clk);
            reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = 32'h8777_7000;
            xl_req_valid = 1'b1; xl_req_addr = BASE + 2 * 4096 + 32'h321;
            @(posedge clk); #1;
            chk("R11 old entry", xl_resp_paddr, old_exp[31:0]);
            @(negedge clk);
            reg_wr = 1'b0; xl_req_valid = 1'b0;
            model[2] = 32'h8777_7000;
        end
        xl_check("R11 new entry", BASE + 2 * 4096 + 32'h321);

        // R11: same-cycle enable clear uses old enable
        begin
            logic [32:0] old_exp;
            old_exp = expect_xl(BASE + 32'h44);
            @(negedge clk);
            reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 32'h0;
            xl_req_valid = 1'b1; xl_req_addr = BASE + 32'h44;
            @(posedge clk); #1;
            chk("R11 old enable", {xl_resp_fault, xl_resp_paddr[30:0]},
                {old_exp[32], old_exp[30:0]});
            @(negedge clk);
            reg_wr = 1'b0; xl_req_valid = 1'b0;
            en_model = 1'b0;
        end
        xl_check("R6 after clear", BASE + 32'h44);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule